// File: doc/BRIEF.md
# MIDI Serial Byte Receiver

This block recovers bytes from a MIDI serial line: asynchronous 8N1 framing at a fixed 31,250 bit/s. With a 4 MHz core clock, each bit lasts 32 µs. The raw line first passes through a two-flop synchronizer. A divider then makes a sampling tick every 2 µs, which gives sixteen ticks per bit. The receiver watches the line on each tick. A frame begins when the line is seen high on one tick and low on the next.

After that falling edge, the receiver confirms the start bit near half a bit time. A start bit that is not still low is treated as a glitch, and the frame is dropped. The eight data bits are taken least significant bit first, each near its centre, and the stop bit is checked one bit later. A build-time option replaces the single centre sample with a majority of three samples taken on adjacent ticks.

When a frame completes, the byte is presented together with a one-cycle valid strobe and a framing-error flag. Both the byte and the flag are held until the next completed frame. The receiver goes straight back to idle, so a new start bit may follow the stop bit with no gap.

Top module: `midi_byte_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rx_valid` is 0 and the receiver is idle. `rx_byte` and `rx_frame_err` reset to 0, and the synchronizer resets to the idle-high line level.
- R2: One sampling tick occurs every `TICK_DIV` clocks (default 8), and one bit lasts `TICKS_PER_BIT` ticks (default 16). The stop-bit decision falls 9.5 bit times plus one tick after the tick that saw the falling edge. With the defaults, that is 1224 clocks.
- R3: The line passes through two flops before any logic uses it, so a line change reaches the receiver no sooner than two clocks later.
- R4: A frame starts only on a tick on which the synchronized line is low and the value taken on the previous tick was high.
- R5: If the start bit is not low when sampled half a bit time after the edge, no byte is reported, and the receiver waits for a new falling edge.
- R6: Data bits are sampled at 1.5 through 8.5 bit times after the edge. The first data bit on the wire becomes `rx_byte[0]`, and the last becomes `rx_byte[7]`.
- R7: If the stop bit sampled at 9.5 bit times is low, `rx_frame_err` is 1 for that byte. If it is high, the flag is 0. The flag changes only together with `rx_valid`.
- R8: `rx_valid` is high for exactly one clock per completed frame. `rx_byte` and `rx_frame_err` stay unchanged until the next completed frame.
- R9: A start bit that follows the stop bit at once, with no idle time, is received correctly.
- R10: With `VOTE`=1, each bit value is the majority of three samples taken on consecutive ticks around the centre. A line disturbance shorter than one tick does not change the received bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock (4 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_byte | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-clock strobe when a frame completes |
| rx_frame_err | output | 1 | Stop bit of the last frame was low |

## Verification
The assertions take for granted that `rx_line` holds each bit for a whole bit time of `TICK_DIV*TICKS_PER_BIT` clocks. Apart from deliberate glitches, they also assume it makes no other transitions. The stimulus drives every bit for exactly 128 clocks, changing the line only just after a falling clock edge. The deliberate disturbances are either a low pulse well shorter than half a bit time or a pulse shorter than one tick. Because the line is asynchronous to the tick, sample timing may drift by up to one tick. The bench therefore accepts a timing window rather than an exact cycle, and it judges the single-sample receiver only on clean frames.

// File: rtl/midi_rx_pkg.sv
package midi_rx_pkg;

    // Receiver control state
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;

    // Three line samples taken on consecutive ticks, oldest first
    typedef struct packed {
        logic early;
        logic mid;
        logic late;
    } tri_sample_t;

    // Completed-frame result carried to the output register
    typedef struct packed {
        logic valid;
        logic err;
    } frame_flags_t;

    function automatic logic maj3(input tri_sample_t s);
        return (s.early & s.mid) | (s.early & s.late) | (s.mid & s.late);
    endfunction

endpackage

// File: rtl/midi_rx_sync.sv
module midi_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[g] <= 1'b1;
                end else if (g == 0) begin
                    chain_q[g] <= async_in;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sync_out) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/midi_rx_tick.sv
module midi_rx_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = !rst && (div_q == LAST);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/midi_rx_sampler.sv
module midi_rx_sampler
    import midi_rx_pkg::*;
#(
    parameter bit VOTE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    output logic fall_seen,
    output logic bit_val
);

    // hist_q[0] holds the value taken on the previous tick, hist_q[1] the one before
    logic [1:0]  hist_q;
    tri_sample_t win;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 2'b11;
        end else if (tick) begin
            hist_q <= {hist_q[0], line};
        end
    end

    assign win       = '{early: hist_q[1], mid: hist_q[0], late: line};
    assign fall_seen = tick && hist_q[0] && !line;

    generate
        if (VOTE) begin : g_vote
            assign bit_val = maj3(win);
        end else begin : g_single
            assign bit_val = win.mid;
        end
    endgenerate

    // R4
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        fall_seen |-> (tick && !line));

endmodule

// File: rtl/midi_rx_fsm.sv
module midi_rx_fsm
    import midi_rx_pkg::*;
#(
    parameter int DATA_BITS     = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 fall_seen,
    input  logic                 bit_val,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 valid_out,
    output logic                 err_out
);

    localparam int PW          = $clog2(TICKS_PER_BIT);
    localparam int FRAME_BITS  = DATA_BITS + 2;
    localparam int BW          = $clog2(FRAME_BITS);
    localparam logic [PW-1:0] DECIDE = PW'(TICKS_PER_BIT / 2);
    localparam logic [BW-1:0] STOP_IDX = BW'(FRAME_BITS - 1);

    rx_state_e            state_q;
    logic [PW-1:0]        phase_q;
    logic [BW-1:0]        bit_idx_q;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] data_q;
    frame_flags_t         flags_q;
    logic                 decide;

    assign decide = tick && (state_q == ST_FRAME) && (phase_q == DECIDE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            phase_q   <= '0;
            bit_idx_q <= '0;
            shift_q   <= '0;
            data_q    <= '0;
            flags_q   <= '0;
        end else begin
            flags_q.valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (fall_seen) begin
                        state_q   <= ST_FRAME;
                        phase_q   <= '0;
                        bit_idx_q <= '0;
                    end
                end
                ST_FRAME: begin
                    if (tick) begin
                        phase_q <= phase_q + 1'b1;
                    end
                    if (decide) begin
                        if (bit_idx_q == '0) begin
                            if (bit_val) begin
                                state_q <= ST_IDLE;
                            end else begin
                                bit_idx_q <= bit_idx_q + 1'b1;
                            end
                        end else if (bit_idx_q == STOP_IDX) begin
                            state_q       <= ST_IDLE;
                            data_q        <= shift_q;
                            flags_q.valid <= 1'b1;
                            flags_q.err   <= !bit_val;
                        end else begin
                            shift_q   <= {bit_val, shift_q[DATA_BITS-1:1]};
                            bit_idx_q <= bit_idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign data_out  = data_q;
    assign valid_out = flags_q.valid;
    assign err_out   = flags_q.err;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == ST_IDLE && !valid_out));

    // R4
    start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FRAME && $past(state_q) == ST_IDLE) |-> $past(tick));

    // R6
    bit_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        bit_idx_q <= STOP_IDX);

    // R7
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_out) |-> valid_out);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> !valid_out);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_out |-> $stable(data_out));

endmodule

// File: rtl/midi_byte_rx.sv
module midi_byte_rx #(
    parameter int DATA_BITS     = 8,
    parameter int TICK_DIV      = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2,
    parameter bit VOTE          = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);

    logic line_s;
    logic tick;
    logic fall_seen;
    logic bit_val;

    midi_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (rx_line),
        .sync_out (line_s)
    );

    midi_rx_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    midi_rx_sampler #(.VOTE(VOTE)) u_samp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .line      (line_s),
        .fall_seen (fall_seen),
        .bit_val   (bit_val)
    );

    midi_rx_fsm #(
        .DATA_BITS     (DATA_BITS),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .fall_seen (fall_seen),
        .bit_val   (bit_val),
        .data_out  (rx_byte),
        .valid_out (rx_valid),
        .err_out   (rx_frame_err)
    );

endmodule

// File: tb/midi_byte_rx_tb_top.sv
module midi_byte_rx_tb_top;

    localparam int BIT_CLKS = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_line = 1'b1;
    always #10 clk = ~clk;

    logic [7:0] byte_a, byte_b;
    logic       val_a, val_b, err_a, err_b;

    midi_byte_rx #(.VOTE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .rx_line(rx_line),
        .rx_byte(byte_a), .rx_valid(val_a), .rx_frame_err(err_a)
    );

    midi_byte_rx #(.VOTE(1'b1)) dut_vote_i (
        .clk(clk), .rst(rst), .rx_line(rx_line),
        .rx_byte(byte_b), .rx_valid(val_b), .rx_frame_err(err_b)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int nval_a = 0, nval_b = 0;
    int vcyc_a = 0;
    logic [7:0] log_a [0:63];
    logic [7:0] log_b [0:63];
    logic       elog_a [0:63];
    logic       elog_b [0:63];
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (val_a) begin
            log_a[nval_a[5:0]]  = byte_a;
            elog_a[nval_a[5:0]] = err_a;
            vcyc_a = cyc;
            nval_a = nval_a + 1;
        end
        if (val_b) begin
            log_b[nval_b[5:0]]  = byte_b;
            elog_b[nval_b[5:0]] = err_b;
            nval_b = nval_b + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v);
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold(b[i], BIT_CLKS);
        hold(stop_v, BIT_CLKS);
        rx_line = 1'b1;
    endtask

    task automatic settle();
        repeat (300) @(negedge clk);
    endtask

    task automatic t_reset();
        check(val_a == 1'b0, "R1", "valid in reset", int'(val_a), 0);
        check(byte_a == 8'h00, "R1", "byte in reset", int'(byte_a), 0);
        check(err_a == 1'b0, "R1", "err in reset", int'(err_a), 0);
        rst = 1'b0;
        @(negedge clk);
        check(val_a == 1'b0, "R1", "valid after reset", int'(val_a), 0);
    endtask

    task automatic t_byte(input logic [7:0] b, input string req);
        int n0, nb0, t0, lat;
        n0 = nval_a; nb0 = nval_b; t0 = cyc;
        send_frame(b, 1'b1);
        settle();
        check(nval_a == n0 + 1, "R8", "one strobe per frame", nval_a - n0, 1);
        check(log_a[n0[5:0]] == b, req, "single-sample byte", int'(log_a[n0[5:0]]), int'(b));
        check(elog_a[n0[5:0]] == 1'b0, "R7", "no framing error", int'(elog_a[n0[5:0]]), 0);
        check(log_b[nb0[5:0]] == b, "R10", "voting byte", int'(log_b[nb0[5:0]]), int'(b));
        lat = vcyc_a - t0;
        check(lat >= 1220 && lat <= 1245, "R2", "start-to-valid clocks", lat, 1232);
    endtask

    task automatic t_glitch();
        int n0;
        logic [7:0] prev;
        n0 = nval_a; prev = byte_a;
        hold(1'b0, 40);
        hold(1'b1, 1500);
        check(nval_a == n0, "R5", "glitch start produced no byte", nval_a - n0, 0);
        check(byte_a == prev, "R8", "byte held after glitch", int'(byte_a), int'(prev));
        check(val_a == 1'b0, "R3", "short low pulse left no strobe", int'(val_a), 0);
    endtask

    task automatic t_ferr();
        int n0;
        n0 = nval_a;
        send_frame(8'h5A, 1'b0);
        settle();
        check(nval_a == n0 + 1, "R7", "error frame strobes once", nval_a - n0, 1);
        check(elog_a[n0[5:0]] == 1'b1, "R7", "stop low flags error", int'(elog_a[n0[5:0]]), 1);
        check(log_a[n0[5:0]] == 8'h5A, "R6", "byte kept on error", int'(log_a[n0[5:0]]), 'h5A);
        check(err_a == 1'b1, "R8", "error held", int'(err_a), 1);
        t_byte(8'h0F, "R6");
        check(err_a == 1'b0, "R7", "error cleared by good frame", int'(err_a), 0);
    endtask

    task automatic t_back_to_back();
        int n0;
        n0 = nval_a;
        send_frame(8'h12, 1'b1);
        send_frame(8'h34, 1'b1);
        send_frame(8'hC3, 1'b1);
        settle();
        check(nval_a == n0 + 3, "R9", "three gapless frames", nval_a - n0, 3);
        check(log_a[n0[5:0]] == 8'h12, "R9", "first gapless byte", int'(log_a[n0[5:0]]), 'h12);
        check(log_a[(n0+1) & 63] == 8'h34, "R9", "second gapless byte", int'(log_a[(n0+1) & 63]), 'h34);
        check(log_a[(n0+2) & 63] == 8'hC3, "R9", "third gapless byte", int'(log_a[(n0+2) & 63]), 'hC3);
    endtask

    task automatic t_vote();
        int nb0;
        nb0 = nval_b;
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                hold(1'b0, 62);
                hold(1'b1, 6);
                hold(1'b0, 60);
            end else begin
                hold(1'b0, BIT_CLKS);
            end
        end
        hold(1'b1, BIT_CLKS);
        settle();
        check(nval_b == nb0 + 1, "R10", "voting frame strobed", nval_b - nb0, 1);
        check(log_b[nb0[5:0]] == 8'h00, "R10", "sub-tick spike outvoted",
              int'(log_b[nb0[5:0]]), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        repeat (20) @(negedge clk);
        t_byte(8'hA5, "R4");
        t_byte(8'h00, "R6");
        t_byte(8'hFF, "R6");
        t_byte(8'h3C, "R6");
        t_glitch();
        t_ferr();
        t_back_to_back();
        t_vote();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule